// File: doc/BRIEF.md
# Single-Step Trace Exception Controller

This block sits beside a processor core's retire stage and decides when the core must take a single-step trace exception. It owns the live extended status register (EXR), whose bit 7 is the trace-enable flag T and whose bits 2:0 are the interrupt mask level. When T is set, the interrupt control mode is the tracing mode (value 2), and an ordinary instruction retires, the block raises a trace request. The request stays up until the core acknowledges exception entry.

On that acknowledge the live T flag is cleared, so the handler runs untraced. A snapshot of the status register taken at the traced boundary, with T still set, is offered for the core to push on the stack. When the handler's return-from-exception restores that value, tracing resumes from the next instruction. The return instruction itself never triggers a trace.

External interrupts are not blocked by tracing. The block only orders the two: a pending trace wins the instruction boundary, and the interrupt is granted once the trace entry is done.

Top module: `trace_ctrl`

## Requirements
- R1: When retire_i is high, exr_o bit 7 (T) is 1, icm_i equals 2 and retire_rte_i is low, trace_req_o is high from the next cycle.
- R2: When icm_i is not 2 (for example mode 0), a retire never raises trace_req_o, whatever T holds.
- R3: A retire with retire_rte_i high never raises trace_req_o, even with T set in mode 2.
- R4: An entry_ack_i while trace_req_o is high clears exr_o bit 7 on the next cycle, and stack_exr_o holds the status value captured at the traced retire, with bit 7 set.
- R5: Trace entry changes only bit 7. The mask bits 2:0 and all other bits of exr_o keep their values, so the interrupt level is not raised.
- R6: The interrupt mask level in exr_o bits 2:0, including the highest level 7, does not gate trace requests.
- R7: After a restore (restore_en_i) of a value with bit 7 set, the next non-return retire in mode 2 raises trace_req_o.
- R8: trace_req_o stays high until entry_ack_i, and goes low in the cycle after the acknowledge.
- R9: irq_take_o equals irq_pending_i while trace_req_o is low, and is 0 while trace_req_o is high.
- R10: After reset, exr_o is 8'h07 (T clear, mask level 7), trace_req_o is 0 and stack_exr_o is 8'h00.
- R11: A software write (exr_wr_en_i) updates exr_o on the next cycle. A retire in the same cycle as a write that sets T is judged on the old T.
- R12: When several updates land in one cycle, the restore value wins over a software write, and a write wins over the entry clear of T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| retire_i | input | 1 | An instruction completed this cycle |
| retire_rte_i | input | 1 | The retiring instruction is a return-from-exception |
| icm_i | input | 2 | Interrupt control mode (2 enables tracing) |
| entry_ack_i | input | 1 | Core is entering the requested trace exception |
| irq_pending_i | input | 1 | External interrupt request waiting at the boundary |
| exr_wr_en_i | input | 1 | Software write strobe for the status register |
| exr_wr_data_i | input | 8 | Software write value |
| restore_en_i | input | 1 | Return-from-exception restores the status register |
| restore_data_i | input | 8 | Status value popped from the stack |
| trace_req_o | output | 1 | Trace exception request |
| irq_take_o | output | 1 | Interrupt may be taken at this boundary |
| stack_exr_o | output | 8 | Status value to push on trace entry |
| exr_o | output | 8 | Live extended status register |

## Verification
The bench targets the handler's own return, where a design that traces the return instruction would re-enter the handler forever. It also targets a write that sets T in the same cycle as a retire: a design that forwards the new T traces one instruction too early. Simultaneous restore, write and acknowledge cycles expose a wrong update priority, which would lose the restored T. Mode 0 with T set and mask level 7 with T set show whether a design gates tracing on the wrong control, and held requests alongside pending interrupts show whether a design lets the interrupt overtake the trace.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int EXR_W   = 8;
  localparam int T_POS   = 7;
  localparam int IMASK_W = 3;
  localparam int ICM_W   = 2;
  localparam logic [ICM_W-1:0] ICM_TRACE = 2'd2;
  localparam logic [EXR_W-1:0] EXR_RST   = 8'h07;
endpackage

// File: rtl/trace_exr_reg.sv
module trace_exr_reg
  import trace_pkg::*;
#(
  parameter int W    = EXR_W,
  parameter int TP   = T_POS,
  parameter int IMW  = IMASK_W,
  parameter logic [W-1:0] RST_VAL = EXR_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restore_en,
  input  logic [W-1:0] restore_val,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         clr_t,
  output logic [W-1:0] exr_q
);
  logic [W-1:0] exr_d;
  logic         exr_en;

  always_comb begin
    exr_d = exr_q;
    if (restore_en)  exr_d = restore_val;
    else if (wr_en)  exr_d = wr_val;
    else if (clr_t)  exr_d[TP] = 1'b0;
  end

  assign exr_en = restore_en | wr_en | clr_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      exr_q <= RST_VAL;
    else if (exr_en) exr_q <= exr_d;
  end

  a_r4_entry_clears_t: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_t && !restore_en && !wr_en) |=> !exr_q[TP]);

  a_r5_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_t && !restore_en && !wr_en) |=> exr_q[IMW-1:0] == $past(exr_q[IMW-1:0]));

  a_r12_restore_wins: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> exr_q == $past(restore_val));
endmodule

// File: rtl/trace_req_ctl.sv
module trace_req_ctl
  import trace_pkg::*;
#(
  parameter int W   = EXR_W,
  parameter int TP  = T_POS,
  parameter int MW  = ICM_W,
  parameter logic [MW-1:0] MODE_ON = ICM_TRACE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire,
  input  logic          is_rte,
  input  logic [MW-1:0] icm,
  input  logic [W-1:0]  exr_q,
  input  logic          ack,
  output logic          pend_q,
  output logic          clr_t,
  output logic [W-1:0]  snap_q
);
  logic launch;
  logic pend_d;

  always_comb begin
    launch = retire && exr_q[TP] && (icm == MODE_ON) && !is_rte && !pend_q;
    pend_d = launch | (pend_q & ~ack);
    clr_t  = pend_q & ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (launch) snap_q <= exr_q;
  end

  a_r1_request_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && exr_q[TP] && icm == MODE_ON && !is_rte && !pend_q) |=> pend_q);

  a_r2_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (icm != MODE_ON && !pend_q) |=> !pend_q);

  a_r3_rte_untraced: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && is_rte && !pend_q) |=> !pend_q);

  a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q);

  a_r4_snapshot_has_t: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> snap_q[TP]);
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int W  = EXR_W,
  parameter int MW = ICM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire_i,
  input  logic          retire_rte_i,
  input  logic [MW-1:0] icm_i,
  input  logic          entry_ack_i,
  input  logic          irq_pending_i,
  input  logic          exr_wr_en_i,
  input  logic [W-1:0]  exr_wr_data_i,
  input  logic          restore_en_i,
  input  logic [W-1:0]  restore_data_i,
  output logic          trace_req_o,
  output logic          irq_take_o,
  output logic [W-1:0]  stack_exr_o,
  output logic [W-1:0]  exr_o
);
  logic [W-1:0] exr_q;
  logic         pend_q;
  logic         clr_t;

  trace_exr_reg #(.W(W)) u_exr (
    .clk         (clk),
    .rst_n       (rst_n),
    .restore_en  (restore_en_i),
    .restore_val (restore_data_i),
    .wr_en       (exr_wr_en_i),
    .wr_val      (exr_wr_data_i),
    .clr_t       (clr_t),
    .exr_q       (exr_q)
  );

  trace_req_ctl #(.W(W), .MW(MW)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .retire (retire_i),
    .is_rte (retire_rte_i),
    .icm    (icm_i),
    .exr_q  (exr_q),
    .ack    (entry_ack_i),
    .pend_q (pend_q),
    .clr_t  (clr_t),
    .snap_q (stack_exr_o)
  );

  assign trace_req_o = pend_q;
  assign irq_take_o  = irq_pending_i & ~pend_q;
  assign exr_o       = exr_q;

  a_r9_trace_first: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_req_o && irq_pending_i) |-> !irq_take_o);
endmodule

// File: tb/test_trace_ctrl.sv
module test_trace_ctrl;
  logic       clk;
  logic       rst_n;
  logic       retire_i, retire_rte_i, entry_ack_i, irq_pending_i;
  logic [1:0] icm_i;
  logic       exr_wr_en_i, restore_en_i;
  logic [7:0] exr_wr_data_i, restore_data_i;
  logic       trace_req_o, irq_take_o;
  logic [7:0] stack_exr_o, exr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] m_exr, m_snap;
  logic       m_pend;

  trace_ctrl i_trace_ctrl (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .retire_rte_i(retire_rte_i),
    .icm_i(icm_i), .entry_ack_i(entry_ack_i), .irq_pending_i(irq_pending_i),
    .exr_wr_en_i(exr_wr_en_i), .exr_wr_data_i(exr_wr_data_i),
    .restore_en_i(restore_en_i), .restore_data_i(restore_data_i),
    .trace_req_o(trace_req_o), .irq_take_o(irq_take_o),
    .stack_exr_o(stack_exr_o), .exr_o(exr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic launch_of(input logic [7:0] exr, input logic pend);
    return retire_i && exr[7] && (icm_i == 2'd2) && !retire_rte_i && !pend;
  endfunction

  // reference update at a clock edge, from the requirements
  task automatic model_edge();
    logic la;
    logic clr;
    la  = launch_of(m_exr, m_pend);
    clr = m_pend && entry_ack_i;
    if (la) m_snap = m_exr;
    if (restore_en_i)      m_exr = restore_data_i;   // R12
    else if (exr_wr_en_i)  m_exr = exr_wr_data_i;
    else if (clr)          m_exr[7] = 1'b0;          // R4 R5
    m_pend = la | (m_pend & ~entry_ack_i);          // R1 R8
  endtask

  task automatic idle();
    retire_i = 0; retire_rte_i = 0; entry_ack_i = 0; irq_pending_i = 0;
    exr_wr_en_i = 0; restore_en_i = 0; exr_wr_data_i = 0; restore_data_i = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({7'd0, trace_req_o}, {7'd0, m_pend}, "R1/R8 trace_req");
    chk(exr_o, m_exr, "R4/R11/R12 exr");
    chk(stack_exr_o, m_snap, "R4 stack_exr");
    chk({7'd0, irq_take_o}, {7'd0, irq_pending_i & ~m_pend}, "R9 irq_take");
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    idle();
    icm_i = 2'd2;
    rst_n = 1'b0;
    m_exr = 8'h07; m_snap = 8'h00; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(exr_o, 8'h07, "R10");
    chk({7'd0, trace_req_o}, 8'h00, "R10");
    chk(stack_exr_o, 8'h00, "R10");

    // R11: write sets T with a retire in the same cycle, mask level 7
    exr_wr_en_i = 1; exr_wr_data_i = 8'h87; retire_i = 1; tick();
    chk({7'd0, trace_req_o}, 8'h00, "R11");
    chk(exr_o, 8'h87, "R11");
    // R1 R6: next retire traces even at mask level 7
    retire_i = 1; tick();
    chk({7'd0, trace_req_o}, 8'h01, "R1 R6");
    chk(stack_exr_o, 8'h87, "R4");
    // R8 R9: hold while interrupt waits
    irq_pending_i = 1; tick();
    irq_pending_i = 1;
    #1 chk({7'd0, irq_take_o}, 8'h00, "R9");
    tick();
    chk({7'd0, trace_req_o}, 8'h01, "R8");
    // R4 R5: acknowledge
    entry_ack_i = 1; irq_pending_i = 1; tick();
    chk({7'd0, trace_req_o}, 8'h00, "R8");
    chk(exr_o, 8'h07, "R4 R5");
    chk(stack_exr_o, 8'h87, "R4");
    irq_pending_i = 1;
    #1 chk({7'd0, irq_take_o}, 8'h01, "R9");
    tick();
    // handler instruction is not traced
    retire_i = 1; tick();
    chk({7'd0, trace_req_o}, 8'h00, "R4");
    // R3 R7: return restores T, return itself untraced
    retire_i = 1; retire_rte_i = 1; restore_en_i = 1; restore_data_i = 8'h87; tick();
    chk({7'd0, trace_req_o}, 8'h00, "R3");
    chk(exr_o, 8'h87, "R7");
    retire_i = 1; tick();
    chk({7'd0, trace_req_o}, 8'h01, "R7");
    entry_ack_i = 1; tick();
    // R2: mode 0 with T set
    restore_en_i = 1; restore_data_i = 8'h83; tick();
    icm_i = 2'd0; retire_i = 1; tick();
    chk({7'd0, trace_req_o}, 8'h00, "R2");
    icm_i = 2'd2;
    // R12: restore beats write
    restore_en_i = 1; restore_data_i = 8'h05; exr_wr_en_i = 1; exr_wr_data_i = 8'h86; tick();
    chk(exr_o, 8'h05, "R12");
    // R12: write beats entry clear
    exr_wr_en_i = 1; exr_wr_data_i = 8'h81; tick();
    retire_i = 1; tick();
    entry_ack_i = 1; exr_wr_en_i = 1; exr_wr_data_i = 8'h82; tick();
    chk(exr_o, 8'h82, "R12");
    chk({7'd0, trace_req_o}, 8'h00, "R8");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      icm_i         = ($urandom_range(0, 9) < 8) ? 2'd2 : 2'd0;
      retire_i      = !m_pend && ($urandom_range(0, 1) == 1);
      retire_rte_i  = retire_i && ($urandom_range(0, 5) == 0);
      entry_ack_i   = m_pend && ($urandom_range(0, 2) == 0);
      irq_pending_i = $urandom_range(0, 1);
      exr_wr_en_i   = (r < 6);
      exr_wr_data_i = 8'($urandom);
      restore_en_i  = retire_rte_i && ($urandom_range(0, 1) == 1);
      restore_data_i = {$urandom_range(0, 1) == 1, 4'd0, 3'($urandom)};
      #1 chk({7'd0, irq_take_o}, {7'd0, irq_pending_i & ~m_pend}, "R9");
      tick();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule